// File: doc/BRIEF.md
# Read-Port Width Matcher with Byte Reordering

This block is the output stage on the read side of a 36-bit FIFO whose words are built from four 9-bit bytes. It takes one word at a time from the FIFO and hands it to the consumer as one 36-bit transfer, two 18-bit transfers or four 9-bit transfers. A bus-size select chooses the width. In the narrow widths an endian select decides whether the most or the least significant piece leaves first. A byte-reorder mode, usable with any width, rearranges the four bytes of the word before it is cut into pieces.

The consumer sees registered data with a valid flag and takes a piece by raising its read strobe. The stage pops the FIFO only to fill an empty holding register, or in the same cycle that the last piece of the held word is taken. In that second case the next word's first piece follows with no idle cycle. The size, endian and reorder selects are captured while reset is high and are held until the next reset.

Top module: `bsw_rd_stage`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_data` and `fifo_pop` are all zero, even when the FIFO holds data.
- R2: With size code 00, each FIFO word leaves as one transfer carrying all 36 bits.
- R3: With size code 01, each word leaves as two 18-bit pieces on `out_data[17:0]`, and `out_data[35:18]` is zero.
- R4: With size code 10, each word leaves as four 9-bit pieces on `out_data[8:0]`, and `out_data[35:9]` is zero.
- R5: With `cfg_big_endian` = 1, the most significant piece leaves first: bits 35:18 before 17:0 for size 01, and bits 35:27 first for size 10.
- R6: With `cfg_big_endian` = 0, the least significant piece leaves first: bits 17:0 first for size 01, and bits 8:0 first for size 10.
- R7: Let byte B3 be bits 35:27 and B0 be bits 8:0, so the word reads B3 B2 B1 B0. Reorder code 00 keeps that order. Code 01 gives B0 B1 B2 B3. Code 10 gives B2 B3 B0 B1. Code 11 gives B1 B0 B3 B2.
- R8: The reorder is applied to the whole 36-bit word before it is split, and any reorder code works with any size.
- R9: `fifo_pop` is high only when `fifo_empty` is low and one of two conditions holds: no word is held, or the final piece of the held word is being taken. It is high for one clock per word.
- R10: While `out_valid` is high and `out_rd` is low, `out_valid` and `out_data` hold their values.
- R11: The selects are sampled only while `rst` is high. Changing them after reset has no effect until the next reset.
- R12: Size code 11 behaves exactly as size code 00.
- R13: A piece is taken at a rising edge where `out_valid` and `out_rd` are both high. When the final piece is taken and the FIFO is not empty, the next word's first piece is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the selects are captured while it is high |
| cfg_size | input | 2 | Transfer width: 00 = 36 bits, 01 = 18 bits, 10 = 9 bits, 11 = 36 bits |
| cfg_big_endian | input | 1 | 1 = most significant piece first, 0 = least significant piece first |
| cfg_swap | input | 2 | Byte reorder code (see R7) |
| fifo_data | input | 36 | Head word of the FIFO, valid while `fifo_empty` is low |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Removes the head word of the FIFO at this clock edge |
| out_data | output | 36 | Current piece, in the low lanes; the unused upper lanes are zero |
| out_valid | output | 1 | `out_data` holds a piece |
| out_rd | input | 1 | Consumer takes the current piece |

## Verification
The case of interest is the cycle in which the consumer takes the last piece of a word and the stage also pops the FIFO to reload. It is provoked by loading several words into the FIFO model during reset and holding `out_rd` high from release, both at full width and at byte width. Each piece is compared in order against a scoreboard built from the reorder and endian rules. A count of cycles with `out_valid` low while expected pieces remain must be zero. A manual-strobe run then counts the pops seen at the FIFO model piece by piece, to show that the pop lands only on the final piece.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_ALT  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    SW_NONE    = 2'd0,
    SW_REVERSE = 2'd1,
    SW_PAIRS   = 2'd2,
    SW_HALVES  = 2'd3
  } swap_e;

  typedef struct packed {
    size_e size;
    logic  big_end;
    swap_e swap;
  } cfg_t;

endpackage

// File: rtl/bsw_cfg_latch.sv
module bsw_cfg_latch
  import bsw_pkg::*;
#(
  parameter int NB   = 4,
  parameter int IDXW = $clog2(NB),
  parameter int LW   = $clog2(IDXW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg_in,
  output cfg_t          cfg_q,
  output logic [LW-1:0] nlog_q
);

  // Selects are captured only while reset is held; they then stay frozen.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_in;
      case (cfg_in.size)
        SZ_HALF: nlog_q <= LW'(1);
        SZ_BYTE: nlog_q <= LW'(IDXW);
        default: nlog_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bsw_byte_swap.sv
module bsw_byte_swap
  import bsw_pkg::*;
#(
  parameter int BW   = 9,
  parameter int NB   = 4,
  parameter int DW   = BW * NB,
  parameter int IDXW = $clog2(NB)
) (
  input  logic [DW-1:0] din,
  input  swap_e         mode,
  output logic [DW-1:0] dout
);

  // Each reorder mode is an XOR on the byte index.
  logic [IDXW-1:0] mask;

  always_comb begin
    case (mode)
      SW_NONE:    mask = '0;
      SW_REVERSE: mask = IDXW'(NB - 1);
      SW_PAIRS:   mask = IDXW'(1);
      default:    mask = IDXW'(NB / 2);
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [IDXW-1:0] src;
    assign src = IDXW'(i) ^ mask;
    assign dout[i*BW +: BW] = din[src*BW +: BW];
  end

endmodule

// File: rtl/bsw_piece_sel.sv
module bsw_piece_sel #(
  parameter int BW   = 9,
  parameter int NB   = 4,
  parameter int DW   = BW * NB,
  parameter int IDXW = $clog2(NB),
  parameter int LW   = $clog2(IDXW + 1)
) (
  input  logic [DW-1:0]   word,
  input  logic [LW-1:0]   nlog,
  input  logic            big_end,
  input  logic [IDXW-1:0] idx,
  output logic [DW-1:0]   piece
);

  localparam int PWW = IDXW + 1;

  logic [IDXW-1:0] last_idx;
  logic [IDXW-1:0] pos;
  logic [IDXW-1:0] base;
  logic [PWW-1:0]  pw;

  // pw counts bytes per piece; base is the first byte of the chosen piece.
  always_comb begin
    last_idx = IDXW'((32'd1 << nlog) - 32'd1);
    pos      = big_end ? (last_idx - idx) : idx;
    base     = IDXW'(pos << (IDXW - int'(nlog)));
    pw       = PWW'(1) << (IDXW - int'(nlog));
  end

  for (genvar j = 0; j < NB; j++) begin : g_out
    logic [IDXW-1:0] sel;
    assign sel = base + IDXW'(j);
    assign piece[j*BW +: BW] = (PWW'(j) < pw) ? word[sel*BW +: BW] : '0;
  end

endmodule

// File: rtl/bsw_rd_stage.sv
module bsw_rd_stage
  import bsw_pkg::*;
#(
  parameter  int BW = 9,
  parameter  int NB = 4,
  localparam int DW = BW * NB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_big_endian,
  input  logic [1:0]    cfg_swap,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_empty,
  output logic          fifo_pop,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_rd
);

  localparam int IDXW = $clog2(NB);
  localparam int LW   = $clog2(IDXW + 1);
  localparam int HW   = BW * (NB / 2);

  cfg_t            cfg_in;
  cfg_t            cfg_q;
  logic [LW-1:0]   nlog_q;
  logic [DW-1:0]   swapped;
  logic [DW-1:0]   piece_n;

  logic [DW-1:0]   word_q, word_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic            vld_q, vld_n;
  logic [IDXW-1:0] last_idx;
  logic            is_last, take, load;

  assign cfg_in = '{size: size_e'(cfg_size), big_end: cfg_big_endian, swap: swap_e'(cfg_swap)};

  bsw_cfg_latch #(.NB(NB), .IDXW(IDXW), .LW(LW)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q),
    .nlog_q (nlog_q)
  );

  bsw_byte_swap #(.BW(BW), .NB(NB), .DW(DW), .IDXW(IDXW)) u_swap (
    .din  (fifo_data),
    .mode (cfg_q.swap),
    .dout (swapped)
  );

  // Pop on an empty holder, or together with the final piece (no bubble).
  assign last_idx = IDXW'((32'd1 << nlog_q) - 32'd1);
  assign is_last  = (idx_q == last_idx);
  assign take     = vld_q & out_rd;
  assign load     = ~rst & ~fifo_empty & (~vld_q | (take & is_last));
  assign fifo_pop = load;

  always_comb begin
    vld_n  = vld_q;
    idx_n  = idx_q;
    word_n = word_q;
    if (load) begin
      vld_n  = 1'b1;
      idx_n  = '0;
      word_n = swapped;
    end else if (take) begin
      if (is_last) vld_n = 1'b0;
      else         idx_n = idx_q + IDXW'(1);
    end
  end

  // The piece is chosen from the next state so that out_data is a register.
  bsw_piece_sel #(.BW(BW), .NB(NB), .DW(DW), .IDXW(IDXW), .LW(LW)) u_sel (
    .word    (word_n),
    .nlog    (nlog_q),
    .big_end (cfg_q.big_end),
    .idx     (idx_n),
    .piece   (piece_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= 1'b0;
      idx_q    <= '0;
      word_q   <= '0;
      out_data <= '0;
    end else begin
      vld_q    <= vld_n;
      idx_q    <= idx_n;
      word_q   <= word_n;
      out_data <= vld_n ? piece_n : '0;
    end
  end

  assign out_valid = vld_q;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_data == '0));

  a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r9_no_pop_while_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_rd) |-> !fifo_pop);

  a_r10_hold_piece: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_rd) |=> (out_valid && $stable(out_data)));

  a_r13_refill_next: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> out_valid);

  a_r3_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_q.size == SZ_HALF) |-> (out_data[DW-1:HW] == '0));

  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_q.size == SZ_BYTE) |-> (out_data[DW-1:BW] == '0));

  a_r7_bits_kept: assert property (@(posedge clk) disable iff (rst)
    !fifo_empty |-> ($countones(swapped) == $countones(fifo_data)));

endmodule

// File: tb/sim_bsw_rd_stage.sv
module sim_bsw_rd_stage;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_size = 2'd0;
  logic        cfg_big_endian = 1'b0;
  logic [1:0]  cfg_swap = 2'd0;
  logic [35:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic [35:0] out_data;
  logic        out_valid;
  logic        out_rd = 1'b0;

  always #4 clk = ~clk;

  bsw_rd_stage u0 (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_big_endian(cfg_big_endian),
    .cfg_swap(cfg_swap), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .out_data(out_data), .out_valid(out_valid), .out_rd(out_rd)
  );

  int checks = 0;
  int errors = 0;
  logic [35:0] fq[$];
  logic [35:0] eqd[$];
  string       eqt[$];
  int          mode = 0;
  int          budget = 0;
  bit          pop_pend = 0;
  bit          stream_chk = 0;
  bit          seen_valid = 0;
  int          bubbles = 0;
  bit          hold_prev = 0;
  logic [35:0] hold_val = '0;
  logic [15:0] lf = 16'hACE1;
  int          tb_size = 0;
  bit          tb_be = 0;
  int          tb_sw = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] ref_swap(input logic [35:0] w, input int sw);
    case (sw)
      1: return {w[8:0], w[17:9], w[26:18], w[35:27]};
      2: return {w[26:18], w[35:27], w[8:0], w[17:9]};
      3: return {w[17:0], w[35:18]};
      default: return w;
    endcase
  endfunction

  // Driver: the word goes to the FIFO model, its expected pieces to the scoreboard.
  task automatic push_word(input logic [35:0] w, input string tag);
    logic [35:0] s, msk, pc;
    int n, wid, pos;
    s = ref_swap(w, tb_sw);
    n = (tb_size == 1) ? 2 : (tb_size == 2) ? 4 : 1;
    wid = 36 / n;
    msk = (36'h1 << wid) - 36'h1;
    for (int k = 0; k < n; k++) begin
      pos = tb_be ? (n - 1 - k) : k;
      pc = (s >> (pos * wid)) & msk;
      eqd.push_back(pc);
      eqt.push_back(tag);
    end
    fq.push_back(w);
    fifo_empty = 1'b0;
    fifo_data  = fq[0];
  endtask

  // FIFO model, consumer and monitor, all working at the falling edge.
  always @(negedge clk) begin
    logic rd;
    logic [35:0] tmp;
    if (pop_pend) begin
      if (fq.size() > 0) tmp = fq.pop_front();
      pop_pend = 0;
    end
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 36'h0 : fq[0];
    case (mode)
      0: rd = 1'b1;
      1: rd = lf[0] | lf[3];
      default: rd = (budget > 0);
    endcase
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (!rst) begin
      if (hold_prev) chk(out_valid && out_data == hold_val, "R10", out_data, hold_val);
      if (out_valid) seen_valid = 1;
      if (stream_chk && seen_valid && eqd.size() > 0 && !out_valid) bubbles++;
      if (out_valid && rd) begin
        if (eqd.size() == 0) chk(0, "R9 unexpected piece", out_data, 36'h0);
        else begin
          tmp = eqd.pop_front();
          chk(out_data == tmp, eqt.pop_front(), out_data, tmp);
        end
        if (mode == 2) budget--;
      end
      hold_prev = out_valid && !rd;
      hold_val  = out_data;
    end else hold_prev = 0;
    out_rd = rd;
    #1 pop_pend = fifo_pop;
  end

  task automatic begin_reset(input int sz, input bit be, input int sw, input int md);
    @(negedge clk); #2;
    rst = 1'b1;
    cfg_size = sz[1:0]; cfg_big_endian = be; cfg_swap = sw[1:0];
    tb_size = sz; tb_be = be; tb_sw = sw; mode = md;
    seen_valid = 0; bubbles = 0; stream_chk = 0;
    repeat (2) @(negedge clk);
    #2;
  endtask

  task automatic end_reset();
    @(negedge clk); #2;
    chk(!out_valid, "R1", {35'h0, out_valid}, 36'h0);
    chk(out_data == 36'h0, "R1", out_data, 36'h0);
    chk(!fifo_pop, "R1", {35'h0, fifo_pop}, 36'h0);
    @(negedge clk);
    rst = 1'b0;
    // R11: scramble the selects; the latched values must still govern.
    cfg_size = cfg_size ^ 2'b10; cfg_big_endian = ~cfg_big_endian; cfg_swap = ~cfg_swap;
  endtask

  task automatic drain(input string tag);
    int i;
    for (i = 0; i < 3000; i++) begin
      if (eqd.size() == 0 && fq.size() == 0) break;
      @(negedge clk);
    end
    if (i == 3000) chk(0, {tag, " drain timeout"}, 36'(eqd.size()), 36'h0);
    repeat (3) @(negedge clk);
    #2;
    chk(!out_valid && eqd.size() == 0, tag, {35'h0, out_valid}, 36'h0);
  endtask

  function automatic logic [35:0] mk(input int a, input int b, input int c, input int d);
    return {a[8:0], b[8:0], c[8:0], d[8:0]};
  endfunction

  task automatic run_set(input int sz, input bit be, input int sw, input int md, input string tag);
    begin_reset(sz, be, sw, md);
    push_word(mk(9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4), tag);
    push_word(mk(9'h100, 9'h0FF, 9'h055, 9'h1AA), tag);
    push_word(mk(9'h001, 9'h002, 9'h003, 9'h004), tag);
    end_reset();
    drain(tag);
  endtask

  initial begin
    // R1, R2, R13: full width, streamed with the strobe held high.
    begin_reset(0, 1, 0, 0);
    stream_chk = 1;
    for (int k = 0; k < 4; k++) push_word(mk(k + 9'h10, k + 9'h120, k + 9'h33, k + 9'h1F0), "R2");
    end_reset();
    drain("R2");
    chk(bubbles == 0, "R13 full width", 36'(bubbles), 36'h0);

    // R13: byte width, so the final piece and the refill share a cycle.
    begin_reset(2, 1, 0, 0);
    stream_chk = 1;
    for (int k = 0; k < 3; k++) push_word(mk(k + 9'h40, k + 9'h150, k + 9'h61, k + 9'h172), "R13");
    end_reset();
    drain("R13");
    chk(bubbles == 0, "R13 byte width", 36'(bubbles), 36'h0);

    run_set(1, 1, 0, 1, "R3");
    run_set(1, 0, 0, 1, "R6");
    run_set(2, 1, 0, 1, "R5");
    run_set(2, 0, 0, 1, "R4");
    run_set(0, 0, 1, 1, "R7");
    run_set(0, 1, 2, 1, "R7");
    run_set(0, 0, 3, 1, "R7");
    run_set(2, 0, 1, 1, "R8");
    run_set(1, 1, 2, 1, "R8");
    run_set(2, 1, 3, 0, "R8");
    run_set(3, 1, 1, 1, "R12");
    run_set(1, 0, 2, 1, "R11");

    // R9: the pop comes only with the final piece of the held word.
    begin_reset(2, 1, 0, 2);
    push_word(mk(9'h011, 9'h022, 9'h033, 9'h044), "R9");
    push_word(mk(9'h155, 9'h166, 9'h177, 9'h188), "R9");
    end_reset();
    repeat (3) @(negedge clk); #2;
    chk(fq.size() == 1, "R9 first fill", 36'(fq.size()), 36'd1);
    budget = 3;
    repeat (6) @(negedge clk); #2;
    chk(fq.size() == 1, "R9 three pieces taken", 36'(fq.size()), 36'd1);
    budget = 1;
    repeat (4) @(negedge clk); #2;
    chk(fq.size() == 0, "R9 final piece", 36'(fq.size()), 36'd0);
    chk(out_valid, "R9 next word held", {35'h0, out_valid}, 36'd1);
    budget = 100;
    drain("R9");
    budget = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule